// File: doc/BRIEF.md
# Interrupt Router Configuration Register Unit

This unit sits next to an extended I/O interrupt router and holds the router's configuration. A small 32-bit register bus reaches two words: a read-only capability word, which lists what this instance of the router can do, and a configuration/status word, which software writes to turn those capabilities on. Every bus request is answered exactly one cycle later, either with data or with an error flag. Writes to the configuration word are masked by the capability word. Once the router is enabled, they are locked.

The unit also keeps a destination-core table with one entry per interrupt line. A route write names a group of four lines and carries one byte for each line. How each byte becomes a core number depends on the current encoding mode. With the mode bit clear, the byte is read as a one-hot core mask. With it set, the byte is the core number itself. An entry is rewritten only when the decoded number changes, and that change is announced by a one-cycle strobe for that line. The pending, enable and delivery logic of the router lives elsewhere.

When the instance is built without the virtualization extension, the register window is not decoded and the router comes out of reset already enabled.

Top module: `irq_route_cfg`

## Requirements
- R1: After reset, with the extension present, the status word is 0, every table entry is core 0, no change strobe is high and no response is pending.
- R2: A read of offset 0 returns the capability word: bit 0 set (extension present) and bits 3:1 equal to the CAPS parameter. Any write to offset 0 is answered with an error, and neither word changes.
- R3: An accepted write to offset 4 stores the written value ANDed with the capability word. A read of offset 4 returns the stored status.
- R4: While status bit 1 (ENABLE) is set, a write of a nonzero value to offset 4 is answered with an error and leaves the status unchanged. A write of zero is still accepted and clears the status.
- R5: A request to any offset other than 0 or 4 is answered with an error and read data 0, and it changes nothing.
- R6: A route write to group g updates lines 4g to 4g+3. Line 4g takes bits 7:0 of the route data, and each following line takes the next byte up.
- R7: With status bit 2 (core-number encoding) clear, a byte decodes to the index of its lowest set bit. A byte whose lowest set bit is 4 or higher, and the all-zero byte, decode to core 0.
- R8: With status bit 2 set, the byte value is taken directly as the core number.
- R9: A line's entry is written, and its change strobe is high for exactly the one cycle after the route write, only when the decoded number differs from the stored one. Unchanged lines show no strobe.
- R10: Built without the extension, the unit answers every register request with an error and data 0, and the status word holds bit 1 (ENABLE) set from reset on.
- R11: A request accepted on one clock edge is answered by resp_valid on the next edge. resp_valid is never high without a request on the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Register request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset within the register window |
| req_wdata | input | 32 | Write data |
| resp_valid | output | 1 | Response for the previous cycle's request |
| resp_err | output | 1 | Access error on that response |
| resp_rdata | output | 32 | Read data (0 on writes and errors) |
| route_we | input | 1 | Route write strobe |
| route_grp | input | GRP_W | Group of four lines being routed |
| route_data | input | 32 | One route byte per line, lowest line in bits 7:0 |
| status_o | output | 32 | Current configuration/status word |
| core_map | output | NUM_IRQ*CORE_W | Decoded core number per line, line i at bits i*CORE_W upward |
| map_changed | output | NUM_IRQ | One-cycle strobe per line whose entry just changed |

## Verification
A corrupted status word is visible on status_o at once. It also shows in a read of offset 4 one cycle after the request, in the lock decision for the next configuration write, and in the decode mode of the next route write. A stale or wrong table entry shows on its core_map slice in the cycle after the route write. A missing or extra change strobe is seen in that same cycle and must be gone one cycle later. Each route is therefore checked right after it is issued, and it is also checked again after a mode change, where the same bytes must decode differently.

// File: rtl/irq_cfg_pkg.sv
package irq_cfg_pkg;
   localparam int FEAT_EXIST_BIT = 0;
   localparam int ST_ENABLE_BIT  = 1;
   localparam int ST_CPU_ENC_BIT = 2;
   localparam int ST_INT_ENC_BIT = 3;

   localparam int OFF_FEATURE = 0;
   localparam int OFF_CONFIG  = 4;

   typedef struct packed {
      logic        err;
      logic [31:0] data;
   } bus_resp_t;

   function automatic logic [31:0] feature_word(input bit has_ext, input logic [2:0] caps);
      feature_word = has_ext ? {28'd0, caps, 1'b1} : 32'd0;
   endfunction
endpackage

// File: rtl/irq_route_lane.sv
module irq_route_lane #(
   parameter int CORE_W = 8
) (
   input  logic [7:0]        byte_in,
   input  logic              direct,
   output logic [CORE_W-1:0] core
);
   always_comb begin
      core = '0;
      if (direct) begin
         core = CORE_W'(byte_in);
      end else begin
         // lowest set bit among 3:0 wins; higher bits or zero give core 0
         for (int b = 3; b >= 0; b--) begin
            if (byte_in[b]) core = CORE_W'(b);
         end
      end
   end
endmodule

// File: rtl/irq_route_table.sv
module irq_route_table #(
   parameter int NUM_IRQ = 32,
   parameter int CORE_W  = 8,
   parameter int GRP_W   = 3
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      route_we,
   input  logic [GRP_W-1:0]          route_grp,
   input  logic [31:0]               route_data,
   input  logic                      direct,
   output logic [NUM_IRQ*CORE_W-1:0] core_map,
   output logic [NUM_IRQ-1:0]        map_changed
);
   localparam int LANES = 4;

   logic [CORE_W-1:0] lane_core [LANES];

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      irq_route_lane #(.CORE_W(CORE_W)) u_lane (
         .byte_in (route_data[l*8 +: 8]),
         .direct  (direct),
         .core    (lane_core[l])
      );
   end

   for (genvar i = 0; i < NUM_IRQ; i++) begin : g_ent
      logic [CORE_W-1:0] ent_q;
      logic              chg_q;
      logic              hit;

      assign hit = route_we && (route_grp == GRP_W'(i / LANES))
                   && (lane_core[i % LANES] != ent_q);

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            ent_q <= '0;
            chg_q <= 1'b0;
         end else begin
            chg_q <= hit;
            if (hit) ent_q <= lane_core[i % LANES];
         end
      end

      assign core_map[i*CORE_W +: CORE_W] = ent_q;
      assign map_changed[i]               = chg_q;
   end
endmodule

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
   import irq_cfg_pkg::*;
#(
   parameter int         ADDR_W   = 4,
   parameter bit         HAS_VEXT = 1'b1,
   parameter logic [2:0] CAPS     = 3'b111
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [31:0]       req_wdata,
   output logic              resp_valid,
   output logic              resp_err,
   output logic [31:0]       resp_rdata,
   output logic [31:0]       status
);
   localparam logic [31:0] FEAT     = feature_word(HAS_VEXT, CAPS);
   localparam logic [31:0] ST_RESET = HAS_VEXT ? 32'd0 : (32'd1 << ST_ENABLE_BIT);

   bus_resp_t nxt;
   logic      st_we;

   if (HAS_VEXT) begin : g_win
      logic hit_feat, hit_cfg;
      assign hit_feat = (req_addr == ADDR_W'(OFF_FEATURE));
      assign hit_cfg  = (req_addr == ADDR_W'(OFF_CONFIG));

      always_comb begin
         nxt   = '{err: 1'b0, data: 32'd0};
         st_we = 1'b0;
         if (hit_feat) begin
            if (req_write) nxt.err  = 1'b1;
            else           nxt.data = FEAT;
         end else if (hit_cfg) begin
            if (!req_write)                                    nxt.data = status;
            else if (status[ST_ENABLE_BIT] && req_wdata != 0) nxt.err  = 1'b1;
            else                                               st_we    = 1'b1;
         end else begin
            nxt.err = 1'b1;
         end
      end
   end else begin : g_nowin
      always_comb begin
         nxt   = '{err: 1'b1, data: 32'd0};
         st_we = 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         status     <= ST_RESET;
         resp_valid <= 1'b0;
         resp_err   <= 1'b0;
         resp_rdata <= 32'd0;
      end else begin
         resp_valid <= req_valid;
         resp_err   <= req_valid & nxt.err;
         resp_rdata <= req_valid ? nxt.data : 32'd0;
         if (req_valid && st_we) status <= req_wdata & FEAT;
      end
   end
endmodule

// File: rtl/irq_route_cfg.sv
module irq_route_cfg
   import irq_cfg_pkg::*;
#(
   parameter int         NUM_IRQ  = 32,
   parameter int         CORE_W   = 8,
   parameter int         ADDR_W   = 4,
   parameter bit         HAS_VEXT = 1'b1,
   parameter logic [2:0] CAPS     = 3'b111,
   localparam int        GRP_W    = $clog2(NUM_IRQ / 4)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      req_valid,
   input  logic                      req_write,
   input  logic [ADDR_W-1:0]         req_addr,
   input  logic [31:0]               req_wdata,
   output logic                      resp_valid,
   output logic                      resp_err,
   output logic [31:0]               resp_rdata,
   input  logic                      route_we,
   input  logic [GRP_W-1:0]          route_grp,
   input  logic [31:0]               route_data,
   output logic [31:0]               status_o,
   output logic [NUM_IRQ*CORE_W-1:0] core_map,
   output logic [NUM_IRQ-1:0]        map_changed
);
   if (NUM_IRQ % 4 != 0 || NUM_IRQ < 8) begin : g_bad_irq
      $error("NUM_IRQ must be a multiple of 4 and at least 8");
   end
   if (CORE_W < 2) begin : g_bad_core
      $error("CORE_W must be at least 2");
   end
   if (ADDR_W < 3) begin : g_bad_addr
      $error("ADDR_W must reach offset 4");
   end

   irq_cfg_regs #(
      .ADDR_W   (ADDR_W),
      .HAS_VEXT (HAS_VEXT),
      .CAPS     (CAPS)
   ) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_valid  (req_valid),
      .req_write  (req_write),
      .req_addr   (req_addr),
      .req_wdata  (req_wdata),
      .resp_valid (resp_valid),
      .resp_err   (resp_err),
      .resp_rdata (resp_rdata),
      .status     (status_o)
   );

   irq_route_table #(
      .NUM_IRQ (NUM_IRQ),
      .CORE_W  (CORE_W),
      .GRP_W   (GRP_W)
   ) u_table (
      .clk         (clk),
      .rst_n       (rst_n),
      .route_we    (route_we),
      .route_grp   (route_grp),
      .route_data  (route_data),
      .direct      (status_o[ST_CPU_ENC_BIT]),
      .core_map    (core_map),
      .map_changed (map_changed)
   );
endmodule

// File: rtl/irq_route_cfg_chk.sv
module irq_route_cfg_chk
   import irq_cfg_pkg::*;
#(
   parameter int         NUM_IRQ  = 32,
   parameter int         ADDR_W   = 4,
   parameter bit         HAS_VEXT = 1'b1,
   parameter logic [2:0] CAPS     = 3'b111
) (
   input logic               clk,
   input logic               rst_n,
   input logic               req_valid,
   input logic               req_write,
   input logic [ADDR_W-1:0]  req_addr,
   input logic [31:0]        req_wdata,
   input logic               resp_valid,
   input logic               resp_err,
   input logic [31:0]        resp_rdata,
   input logic               route_we,
   input logic [31:0]        status_o,
   input logic [NUM_IRQ-1:0] map_changed
);
   localparam logic [31:0] FEAT = feature_word(HAS_VEXT, CAPS);

   p_resp_next_r11: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> resp_valid);

   p_no_stray_resp_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !resp_valid);

   p_feat_write_err_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_write && req_addr == ADDR_W'(OFF_FEATURE))
      |=> (resp_err && $stable(status_o)));

   p_status_masked_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !HAS_VEXT || ((status_o & ~FEAT) == 32'd0));

   p_locked_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_write && req_addr == ADDR_W'(OFF_CONFIG)
       && status_o[ST_ENABLE_BIT] && req_wdata != 32'd0)
      |=> (resp_err && $stable(status_o)));

   p_err_no_data_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (resp_valid && resp_err) |-> (resp_rdata == 32'd0));

   p_strobe_needs_route_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (|map_changed) |-> $past(route_we));

   p_enable_forced_r10: assert property (@(posedge clk) disable iff (!rst_n)
      HAS_VEXT || status_o[ST_ENABLE_BIT]);
endmodule

bind irq_route_cfg irq_route_cfg_chk #(
   .NUM_IRQ  (NUM_IRQ),
   .ADDR_W   (ADDR_W),
   .HAS_VEXT (HAS_VEXT),
   .CAPS     (CAPS)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .req_valid   (req_valid),
   .req_write   (req_write),
   .req_addr    (req_addr),
   .req_wdata   (req_wdata),
   .resp_valid  (resp_valid),
   .resp_err    (resp_err),
   .resp_rdata  (resp_rdata),
   .route_we    (route_we),
   .status_o    (status_o),
   .map_changed (map_changed)
);

// File: tb/sim_irq_route_cfg.sv
module sim_irq_route_cfg;
   localparam int NIRQ = 32;
   localparam int CW   = 8;
   localparam int AW   = 4;
   localparam int GW   = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;

   // u0: extension present, all capabilities advertised (capability word 0xF)
   logic            req_valid = 0, req_write = 0;
   logic [AW-1:0]   req_addr = '0;
   logic [31:0]     req_wdata = '0;
   logic            resp_valid, resp_err;
   logic [31:0]     resp_rdata;
   logic            route_we = 0;
   logic [GW-1:0]   route_grp = '0;
   logic [31:0]     route_data = '0;
   logic [31:0]     status_o;
   logic [NIRQ*CW-1:0] core_map;
   logic [NIRQ-1:0] map_changed;

   irq_route_cfg #(.NUM_IRQ(NIRQ), .CORE_W(CW), .ADDR_W(AW), .HAS_VEXT(1'b1), .CAPS(3'b111)) u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata), .resp_valid(resp_valid),
      .resp_err(resp_err), .resp_rdata(resp_rdata), .route_we(route_we),
      .route_grp(route_grp), .route_data(route_data), .status_o(status_o),
      .core_map(core_map), .map_changed(map_changed));

   // u1: extension absent
   logic            b_valid = 0, b_write = 0;
   logic [AW-1:0]   b_addr = '0;
   logic [31:0]     b_wdata = '0;
   logic            b_rvalid, b_rerr;
   logic [31:0]     b_rdata;
   logic [31:0]     b_status;
   logic [NIRQ*CW-1:0] b_map;
   logic [NIRQ-1:0] b_chg;

   irq_route_cfg #(.NUM_IRQ(NIRQ), .CORE_W(CW), .ADDR_W(AW), .HAS_VEXT(1'b0), .CAPS(3'b111)) u1 (
      .clk(clk), .rst_n(rst_n), .req_valid(b_valid), .req_write(b_write),
      .req_addr(b_addr), .req_wdata(b_wdata), .resp_valid(b_rvalid),
      .resp_err(b_rerr), .resp_rdata(b_rdata), .route_we(1'b0),
      .route_grp('0), .route_data(32'd0), .status_o(b_status),
      .core_map(b_map), .map_changed(b_chg));

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   typedef struct {
      logic        err;
      logic [31:0] data;
      string       tag;
   } exp_t;
   exp_t exp_q[$];

   logic [31:0] exp_status = 32'd0;
   logic [CW-1:0] exp_tbl [NIRQ];

   task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n && !done && resp_valid) begin
         if (exp_q.size() == 0) begin
            check(1'b0, "R11 stray response", 64'(resp_valid), 64'd0);
         end else begin
            exp_t e;
            e = exp_q.pop_front();
            check(resp_err == e.err, {e.tag, " err"}, 64'(resp_err), 64'(e.err));
            check(resp_rdata == e.data, {e.tag, " data"}, 64'(resp_rdata), 64'(e.data));
         end
      end
   end

   task automatic bus_op(input bit wr, input logic [AW-1:0] addr, input logic [31:0] wd,
                         input bit e_err, input logic [31:0] e_data, input string tag);
      exp_t e;
      @(negedge clk);
      req_valid = 1; req_write = wr; req_addr = addr; req_wdata = wd;
      e.err = e_err; e.data = e_data; e.tag = tag;
      exp_q.push_back(e);
      @(negedge clk);
      req_valid = 0; req_write = 0;
      check(resp_valid == 1'b1, "R11 response one cycle later", 64'(resp_valid), 64'd1);
   endtask

   function automatic logic [CW-1:0] dec(input logic [7:0] b, input bit direct);
      if (direct) return CW'(b);
      if (b[0]) return 0;
      if (b[1]) return 1;
      if (b[2]) return 2;
      if (b[3]) return 3;
      return 0;
   endfunction

   task automatic route_wr(input logic [GW-1:0] g, input logic [31:0] d, input string tag);
      logic [NIRQ-1:0] exp_chg;
      exp_chg = '0;
      for (int l = 0; l < 4; l++) begin
         int idx;
         logic [CW-1:0] nv;
         idx = int'(g) * 4 + l;
         nv = dec(d[l*8 +: 8], exp_status[2]);
         if (nv != exp_tbl[idx]) begin
            exp_chg[idx] = 1'b1;
            exp_tbl[idx] = nv;
         end
      end
      @(negedge clk);
      route_we = 1; route_grp = g; route_data = d;
      @(negedge clk);
      route_we = 0;
      for (int l = 0; l < 4; l++) begin
         int idx;
         idx = int'(g) * 4 + l;
         check(core_map[idx*CW +: CW] == exp_tbl[idx], {tag, " entry"},
               64'(core_map[idx*CW +: CW]), 64'(exp_tbl[idx]));
      end
      check(map_changed == exp_chg, "R9 change strobe", 64'(map_changed), 64'(exp_chg));
      @(negedge clk);
      check(map_changed == '0, "R9 strobe lasts one cycle", 64'(map_changed), 64'd0);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      check(1'b0, "watchdog expired", 64'd0, 64'd1);
      finish_run();
   end

   initial begin
      for (int i = 0; i < NIRQ; i++) exp_tbl[i] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);

      // R1 reset state
      check(status_o == 32'd0, "R1 status after reset", 64'(status_o), 64'd0);
      check(core_map == '0, "R1 table after reset", 64'(core_map[63:0]), 64'd0);
      check(map_changed == '0, "R1 no strobe after reset", 64'(map_changed), 64'd0);
      check(resp_valid == 1'b0, "R1 no response after reset", 64'(resp_valid), 64'd0);

      // R2 capability word
      bus_op(0, 4'd0, 32'd0, 0, 32'h0000_000F, "R2 read capability");
      bus_op(1, 4'd0, 32'hFF, 1, 32'd0, "R2 write capability refused");
      bus_op(0, 4'd0, 32'd0, 0, 32'h0000_000F, "R2 capability unchanged");
      check(status_o == 32'd0, "R2 status untouched", 64'(status_o), 64'd0);

      // R3 masking
      bus_op(1, 4'd4, 32'h0000_0030, 0, 32'd0, "R3 masked write");
      exp_status = 32'd0;
      check(status_o == exp_status, "R3 high bits dropped", 64'(status_o), 64'(exp_status));

      // R6/R7 one-hot decode
      route_wr(3'd1, 32'h00_08_02_01, "R7 one-hot group1");
      route_wr(3'd0, 32'h10_04_06_30, "R7 one-hot high and zero bits");
      route_wr(3'd1, 32'h00_08_02_01, "R9 repeat no change");
      route_wr(3'd3, 32'h80_40_01_02, "R6 byte order group3");

      // R8 direct mode
      bus_op(1, 4'd4, 32'hFFFF_FFF4, 0, 32'd0, "R3 set encode");
      exp_status = 32'hFFFF_FFF4 & 32'h0000_000F;
      check(status_o == exp_status, "R3 stored masked", 64'(status_o), 64'(exp_status));
      bus_op(0, 4'd4, 32'd0, 0, exp_status, "R3 read config");
      route_wr(3'd7, 32'h05_FF_03_02, "R8 direct group7");
      route_wr(3'd1, 32'h00_08_02_01, "R8 direct group1");

      // R4 lock
      bus_op(1, 4'd4, 32'h0000_000E, 0, 32'd0, "R4 enable");
      exp_status = 32'h0000_000E;
      bus_op(1, 4'd4, 32'h0000_0004, 1, 32'd0, "R4 locked write refused");
      check(status_o == exp_status, "R4 status kept", 64'(status_o), 64'(exp_status));
      bus_op(0, 4'd4, 32'd0, 0, exp_status, "R4 read while locked");
      bus_op(1, 4'd4, 32'd0, 0, 32'd0, "R4 zero write accepted");
      exp_status = 32'd0;
      check(status_o == 32'd0, "R4 cleared", 64'(status_o), 64'd0);

      // R5 bad offsets
      bus_op(0, 4'd8, 32'd0, 1, 32'd0, "R5 read bad offset");
      bus_op(1, 4'd12, 32'h4, 1, 32'd0, "R5 write bad offset");
      bus_op(0, 4'd2, 32'd0, 1, 32'd0, "R5 unaligned offset");
      check(status_o == 32'd0, "R5 status untouched", 64'(status_o), 64'd0);

      // R10 instance without extension
      check(b_status == 32'h2, "R10 enable forced", 64'(b_status), 64'h2);
      @(negedge clk);
      b_valid = 1; b_write = 0; b_addr = 4'd4;
      @(negedge clk);
      b_valid = 0;
      check(b_rvalid && b_rerr && b_rdata == 0, "R10 read refused",
            {31'd0, b_rvalid, b_rerr, b_rdata}, {31'd0, 2'b11, 32'd0});
      @(negedge clk);
      b_valid = 1; b_write = 1; b_addr = 4'd4; b_wdata = 32'd0;
      @(negedge clk);
      b_valid = 0;
      check(b_rvalid && b_rerr, "R10 write refused", {62'd0, b_rvalid, b_rerr}, 64'd3);
      @(negedge clk);
      check(b_status == 32'h2, "R10 status kept", 64'(b_status), 64'h2);

      repeat (2) @(negedge clk);
      check(exp_q.size() == 0, "R11 all responses seen", 64'(exp_q.size()), 64'd0);
      finish_run();
   end
endmodule